// File: doc/BRIEF.md
# Transmit Buffer Ownership Controller

This block follows the life of a single transmit message buffer in a time-triggered bus controller that works in fixed slots. On one side a host issues ownership commands (lock, unlock, enable, disable), writes payload words and sets or clears a commit flag. On the other side a slot scheduler sends three pulses: a search match that marks the buffer as ready for the next slot, a slot start, and a slot-done pulse that follows the end of the transmit slot. The block passes the buffer between the host and the controller and decides at each slot start whether the buffer is sent.

The host may only touch the buffer while it owns it, which means while the buffer is disabled or locked. Any write or commit change made outside those states is dropped and flagged with an error pulse. The controller sends only when the buffer is message-available and still committed at the slot start. After a transmission a timed update step runs. It clears the commit flag unless repeat mode is selected. A lock command that arrives while the controller owns the buffer is held until the controller's own step finishes.

Top module: `txb_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the buffer in state code 0 (host-disabled) with commit, data_valid, ena_stat, lck_stat, tx_active and acc_err all 0.
- R2: buf_state uses these codes: 0 host-disabled, 1 host-disabled-locked, 2 host-locked, 3 host-locked with update pending, 4 host-locked with message-available pending, 5 idle, 6 message-available, 7 transmitting, 8 slot-update. ena_stat is 1 for every code except 0 and 1. lck_stat is 1 exactly for codes 1 to 4.
- R3: host_cmd codes are 1 lock, 2 unlock, 3 enable and 4 disable. Each takes effect on the next clock: code 0 with lock goes to 1 and with enable goes to 5; code 1 with unlock goes to 0 and with enable goes to 2; code 2 with unlock goes to 5 and with disable goes to 1; code 5 with lock goes to 2 and with disable goes to 0. All other command and state pairs leave the state unchanged.
- R4: host_data_wr and host_cmt_wr are accepted only in codes 0 to 4. An accepted data write appears on data_wr_ok in the same cycle, and an accepted commit write loads host_cmt_val into commit on the next clock. A rejected write leaves data_wr_ok low and commit unchanged, and acc_err is high for exactly the next cycle.
- R5: data_valid is 1 only when buf_state is in codes 5 to 8 and commit is 1, so it is 0 in every host-owned state.
- R6: sch_match in code 5 moves the buffer to code 6 on the next clock. sch_match in any other state is ignored.
- R7: sch_slot_start in code 6 with commit 1 moves the buffer to code 7. tx_active is 1 exactly while the buffer is in code 7.
- R8: sch_slot_start in code 6 with commit 0 returns the buffer to code 5, and tx_active stays 0.
- R9: sch_slot_done in code 7 moves the buffer to code 8. After SU_CYCLES clocks in the update step the buffer returns to code 5, and commit is cleared at that point unless cfg_repeat is 1.
- R10: A lock command in code 6 goes to code 4, and a later slot start then goes to code 2 without transmitting. A lock in code 8 goes to code 3, which ends in code 2 when the update step completes. A lock in code 7 is held and sends the buffer to code 3 at sch_slot_done.
- R11: When a scheduler pulse causes a transition in the same cycle as a host command, the scheduler transition is taken and the command is dropped.
- R12: Two instances that share the scheduler pulses and are both matched in one search both transmit in the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cmd | input | 3 | Host command code (0 none, 1 lock, 2 unlock, 3 enable, 4 disable) |
| host_data_wr | input | 1 | Host payload write strobe |
| host_cmt_wr | input | 1 | Host commit-flag write strobe |
| host_cmt_val | input | 1 | Commit value to write |
| cfg_repeat | input | 1 | Keep commit after transmission (resend same data) |
| sch_match | input | 1 | Scheduler search-match pulse |
| sch_slot_start | input | 1 | Scheduler slot-start pulse |
| sch_slot_done | input | 1 | Scheduler slot-status-done pulse |
| buf_state | output | 4 | Current buffer state code |
| ena_stat | output | 1 | Buffer enabled status |
| lck_stat | output | 1 | Buffer host-locked status |
| commit | output | 1 | Commit flag |
| data_valid | output | 1 | Committed data is owned by the controller |
| tx_active | output | 1 | Buffer is transmitting in the current slot |
| data_wr_ok | output | 1 | Gated payload write strobe |
| acc_err | output | 1 | Rejected host access, one-cycle pulse |

## Verification
A wrong state in this block shows on buf_state and on the status bits at the very next clock edge, since those outputs are decoded directly from the state register. A wrong ownership decision shows up in one of three ways. data_wr_ok may pass or block a strobe in the same cycle it is given. acc_err may be missing or appear falsely one cycle later. tx_active may appear or stay absent in the slot that follows a slot start. A wrong commit clear after a transmission appears on commit and data_valid after SU_CYCLES clocks, when the buffer comes back to idle.

// File: rtl/txb_pkg.sv
package txb_pkg;
   localparam int STATE_W = 4;
   localparam int CMD_W   = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_HDIS     = 4'd0,
      ST_HDIS_LCK = 4'd1,
      ST_HLCK     = 4'd2,
      ST_HLCK_SU  = 4'd3,
      ST_HLCK_MA  = 4'd4,
      ST_IDLE     = 4'd5,
      ST_CC_MA    = 4'd6,
      ST_CC_TX    = 4'd7,
      ST_CC_SU    = 4'd8
   } txb_state_e;

   typedef enum logic [CMD_W-1:0] {
      CMD_NONE    = 3'd0,
      CMD_LOCK    = 3'd1,
      CMD_UNLOCK  = 3'd2,
      CMD_ENABLE  = 3'd3,
      CMD_DISABLE = 3'd4
   } txb_cmd_e;

   function automatic logic host_owned(input txb_state_e s);
      return (s == ST_HDIS) || (s == ST_HDIS_LCK) || (s == ST_HLCK) ||
             (s == ST_HLCK_SU) || (s == ST_HLCK_MA);
   endfunction
endpackage

// File: rtl/txb_su_timer.sv
module txb_su_timer #(
   parameter int SU_CYCLES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic in_su,
   output logic su_done
);
   localparam int CNT_W = (SU_CYCLES > 1) ? $clog2(SU_CYCLES) : 1;

   if (SU_CYCLES < 1) begin : g_bad
      $error("SU_CYCLES must be at least 1");
   end

   if (SU_CYCLES == 1) begin : g_single
      assign su_done = in_su;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      assign su_done = in_su && (cnt_q == CNT_W'(SU_CYCLES - 1));
      always_ff @(posedge clk) begin
         if (rst || !in_su || su_done) cnt_q <= '0;
         else                          cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/txb_access.sv
module txb_access
   import txb_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  txb_state_e state,
   input  logic       data_wr,
   input  logic       cmt_wr,
   input  logic       cmt_val,
   input  logic       su_done,
   input  logic       cfg_repeat,
   output logic       commit,
   output logic       data_wr_ok,
   output logic       acc_err
);
   logic own;
   logic su_clr;
   logic commit_q;
   logic err_q;

   assign own        = host_owned(state);
   assign data_wr_ok = data_wr && own;
   assign su_clr     = su_done && !cfg_repeat;
   assign commit     = commit_q;
   assign acc_err    = err_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         commit_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= (data_wr || cmt_wr) && !own;
         if (cmt_wr && own) commit_q <= cmt_val;
         else if (su_clr)   commit_q <= 1'b0;
      end
   end

   a_r4_err_after_reject: assert property (@(posedge clk) disable iff (rst)
      ((cmt_wr || data_wr) && !own) |=> acc_err);

   a_r4_commit_held: assert property (@(posedge clk) disable iff (rst)
      (cmt_wr && !own && !su_done) |=> $stable(commit_q));
endmodule

// File: rtl/txb_fsm.sv
module txb_fsm
   import txb_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic [CMD_W-1:0] cmd,
   input  logic             commit,
   input  logic             match,
   input  logic             slot_start,
   input  logic             slot_done,
   input  logic             su_done,
   output txb_state_e       state
);
   txb_state_e state_q, state_d;
   logic       lock_pend_q;
   logic       is_lock;

   assign is_lock = (cmd == CMD_LOCK);
   assign state   = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HDIS: begin
            if (is_lock)                  state_d = ST_HDIS_LCK;
            else if (cmd == CMD_ENABLE)   state_d = ST_IDLE;
         end
         ST_HDIS_LCK: begin
            if (cmd == CMD_UNLOCK)        state_d = ST_HDIS;
            else if (cmd == CMD_ENABLE)   state_d = ST_HLCK;
         end
         ST_HLCK: begin
            if (cmd == CMD_UNLOCK)        state_d = ST_IDLE;
            else if (cmd == CMD_DISABLE)  state_d = ST_HDIS_LCK;
         end
         ST_HLCK_SU: if (su_done)         state_d = ST_HLCK;
         ST_HLCK_MA: if (slot_start)      state_d = ST_HLCK;
         ST_IDLE: begin
            if (match)                    state_d = ST_CC_MA;
            else if (is_lock)             state_d = ST_HLCK;
            else if (cmd == CMD_DISABLE)  state_d = ST_HDIS;
         end
         ST_CC_MA: begin
            if (slot_start)               state_d = commit ? ST_CC_TX : ST_IDLE;
            else if (is_lock)             state_d = ST_HLCK_MA;
         end
         ST_CC_TX: if (slot_done)         state_d = lock_pend_q ? ST_HLCK_SU : ST_CC_SU;
         ST_CC_SU: begin
            if (su_done)                  state_d = ST_IDLE;
            else if (is_lock)             state_d = ST_HLCK_SU;
         end
         default:                         state_d = ST_HDIS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q     <= ST_HDIS;
         lock_pend_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_CC_TX)            lock_pend_q <= 1'b0;
         else if (is_lock && !slot_done)     lock_pend_q <= 1'b1;
      end
   end

   a_r7_tx_needs_commit: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CC_TX && $past(state_q) != ST_CC_TX) |->
         ($past(state_q) == ST_CC_MA && $past(commit)));

   a_r6_match_from_idle: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && match) |=> (state_q == ST_CC_MA));

   a_r8_uncommitted_drop: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CC_MA && slot_start && !commit) |=> (state_q == ST_IDLE));

   a_r9_done_to_update: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_CC_TX && slot_done) |=>
         (state_q == ST_CC_SU || state_q == ST_HLCK_SU));
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
   import txb_pkg::*;
#(
   parameter int SU_CYCLES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [2:0]          host_cmd,
   input  logic                host_data_wr,
   input  logic                host_cmt_wr,
   input  logic                host_cmt_val,
   input  logic                cfg_repeat,
   input  logic                sch_match,
   input  logic                sch_slot_start,
   input  logic                sch_slot_done,
   output logic [3:0]          buf_state,
   output logic                ena_stat,
   output logic                lck_stat,
   output logic                commit,
   output logic                data_valid,
   output logic                tx_active,
   output logic                data_wr_ok,
   output logic                acc_err
);
   txb_state_e state;
   logic       su_done;
   logic       in_su;

   assign in_su = (state == ST_CC_SU) || (state == ST_HLCK_SU);

   txb_su_timer #(.SU_CYCLES(SU_CYCLES)) u_timer (
      .clk(clk), .rst(rst), .in_su(in_su), .su_done(su_done)
   );

   txb_fsm u_fsm (
      .clk(clk), .rst(rst), .cmd(host_cmd), .commit(commit),
      .match(sch_match), .slot_start(sch_slot_start),
      .slot_done(sch_slot_done), .su_done(su_done), .state(state)
   );

   txb_access u_acc (
      .clk(clk), .rst(rst), .state(state), .data_wr(host_data_wr),
      .cmt_wr(host_cmt_wr), .cmt_val(host_cmt_val), .su_done(su_done),
      .cfg_repeat(cfg_repeat), .commit(commit),
      .data_wr_ok(data_wr_ok), .acc_err(acc_err)
   );

   assign buf_state  = state;
   assign ena_stat   = (state != ST_HDIS) && (state != ST_HDIS_LCK);
   assign lck_stat   = (state == ST_HDIS_LCK) || (state == ST_HLCK) ||
                       (state == ST_HLCK_SU) || (state == ST_HLCK_MA);
   assign tx_active  = (state == ST_CC_TX);
   assign data_valid = !host_owned(state) && commit;

   a_r5_no_valid_when_locked: assert property (@(posedge clk) disable iff (rst)
      lck_stat |-> !data_valid);

   a_r10_locked_never_sends: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HLCK_MA) |=> !tx_active);
endmodule

// File: tb/txb_ctrl_tb.sv
module txb_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SU_CYC     = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] cmd [2];
   logic [1:0] dwr, cwr, cval, rep;
   logic       match = 1'b0, sstart = 1'b0, sdone = 1'b0;
   logic [3:0] st [2];
   logic [1:0] ena, lck, cmt, val, txa, wok, err;
   int         checks = 0, errors = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txb_ctrl #(.SU_CYCLES(SU_CYC)) u_dut (
      .clk(clk), .rst(rst), .host_cmd(cmd[0]), .host_data_wr(dwr[0]),
      .host_cmt_wr(cwr[0]), .host_cmt_val(cval[0]), .cfg_repeat(rep[0]),
      .sch_match(match), .sch_slot_start(sstart), .sch_slot_done(sdone),
      .buf_state(st[0]), .ena_stat(ena[0]), .lck_stat(lck[0]), .commit(cmt[0]),
      .data_valid(val[0]), .tx_active(txa[0]), .data_wr_ok(wok[0]), .acc_err(err[0]));

   txb_ctrl #(.SU_CYCLES(SU_CYC)) u_dut_b (
      .clk(clk), .rst(rst), .host_cmd(cmd[1]), .host_data_wr(dwr[1]),
      .host_cmt_wr(cwr[1]), .host_cmt_val(cval[1]), .cfg_repeat(rep[1]),
      .sch_match(match), .sch_slot_start(sstart), .sch_slot_done(sdone),
      .buf_state(st[1]), .ena_stat(ena[1]), .lck_stat(lck[1]), .commit(cmt[1]),
      .data_valid(val[1]), .tx_active(txa[1]), .data_wr_ok(wok[1]), .acc_err(err[1]));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic host_cmd(input int i, input logic [2:0] c);
      cmd[i] = c; step(); cmd[i] = 3'd0;
   endtask

   task automatic host_commit(input int i, input logic v);
      cwr[i] = 1'b1; cval[i] = v; step(); cwr[i] = 1'b0;
   endtask

   task automatic pulse_match();  match = 1'b1;  step(); match = 1'b0;  endtask
   task automatic pulse_start();  sstart = 1'b1; step(); sstart = 1'b0; endtask
   task automatic pulse_done();   sdone = 1'b1;  step(); sdone = 1'b0;  endtask

   task automatic t_reset();
      chk("R1 state", st[0], 0);
      chk("R1 commit", cmt[0], 0);
      chk("R1 valid", val[0], 0);
      chk("R1 ena", ena[0], 0);
      chk("R1 lck", lck[0], 0);
      chk("R1 tx", txa[0], 0);
      chk("R1 err", err[0], 0);
   endtask

   task automatic t_host_setup();
      host_cmd(0, 3'd3);
      chk("R3 enable to idle", st[0], 5);
      chk("R2 ena idle", ena[0], 1);
      chk("R2 lck idle", lck[0], 0);
      host_commit(0, 1'b1);
      chk("R4 err after bad commit", err[0], 1);
      chk("R4 commit unchanged", cmt[0], 0);
      step();
      chk("R4 err one cycle", err[0], 0);
      host_cmd(0, 3'd1);
      chk("R3 lock to hlck", st[0], 2);
      chk("R2 lck hlck", lck[0], 1);
      dwr[0] = 1'b1; #1;
      chk("R4 data write passes", wok[0], 1);
      step(); dwr[0] = 1'b0;
      chk("R4 no err on good write", err[0], 0);
      host_commit(0, 1'b1);
      chk("R4 commit loaded", cmt[0], 1);
      chk("R5 no valid when locked", val[0], 0);
      host_cmd(0, 3'd2);
      chk("R3 unlock to idle", st[0], 5);
      chk("R5 valid in idle", val[0], 1);
      host_cmd(1, 3'd1);
      chk("R3 lock from hdis", st[1], 1);
      host_cmd(1, 3'd3);
      chk("R3 enable from hdis_lck", st[1], 2);
      host_commit(1, 1'b1);
      host_cmd(1, 3'd2);
      chk("R3 b idle", st[1], 5);
   endtask

   task automatic t_two_buffers();
      pulse_match();
      chk("R6 match a", st[0], 6);
      chk("R12 match b", st[1], 6);
      pulse_start();
      chk("R7 a transmitting", st[0], 7);
      chk("R7 a tx_active", txa[0], 1);
      chk("R12 b tx_active", txa[1], 1);
      pulse_done();
      chk("R9 a update", st[0], 8);
      chk("R7 tx dropped", txa[0], 0);
      repeat (SU_CYC - 1) step();
      chk("R9 still updating", st[0], 8);
      step();
      chk("R9 back to idle", st[0], 5);
      chk("R9 commit cleared", cmt[0], 0);
      chk("R9 repeat keeps commit", cmt[1], 1);
   endtask

   task automatic t_no_commit();
      pulse_match();
      pulse_start();
      chk("R8 uncommitted to idle", st[0], 5);
      chk("R8 no tx", txa[0], 0);
      chk("R12 b sends again", txa[1], 1);
      pulse_done();
      repeat (SU_CYC) step();
      chk("R9 b idle", st[1], 5);
   endtask

   task automatic t_lock_ctrl();
      pulse_match();
      host_cmd(0, 3'd1);
      chk("R10 lock in ma", st[0], 4);
      chk("R5 valid low hlck_ma", val[0], 0);
      pulse_start();
      chk("R10 settles hlck", st[0], 2);
      chk("R10 no tx", txa[0], 0);
      pulse_done();
      repeat (SU_CYC) step();
      host_commit(0, 1'b1);
      host_cmd(0, 3'd2);
      pulse_match();
      pulse_start();
      chk("R7 tx again", st[0], 7);
      host_cmd(0, 3'd1);
      chk("R10 lock held in tx", st[0], 7);
      pulse_done();
      chk("R10 deferred lock", st[0], 3);
      repeat (SU_CYC) step();
      chk("R10 update ends locked", st[0], 2);
      chk("R9 commit cleared locked", cmt[0], 0);
      match = 1'b1; step(); match = 1'b0;
      chk("R6 match ignored", st[0], 2);
      host_cmd(0, 3'd4);
      chk("R3 disable to hdis_lck", st[0], 1);
      host_cmd(0, 3'd3);
      host_cmd(0, 3'd2);
   endtask

   task automatic t_priority();
      match = 1'b1; cmd[0] = 3'd1; step(); match = 1'b0; cmd[0] = 3'd0;
      chk("R11 scheduler wins", st[0], 6);
      dwr[0] = 1'b1; #1;
      chk("R4 write blocked", wok[0], 0);
      step(); dwr[0] = 1'b0;
      chk("R4 err in ma", err[0], 1);
      pulse_start();
      chk("R8 back to idle", st[0], 5);
      host_cmd(0, 3'd4);
      chk("R3 idle disable", st[0], 0);
   endtask

   initial begin
      cmd[0] = '0; cmd[1] = '0;
      dwr = '0; cwr = '0; cval = '0; rep = 2'b10;
      repeat (3) step();
      t_reset();
      rst = 1'b0;
      step();
      t_host_setup();
      t_two_buffers();
      t_no_commit();
      t_lock_ctrl();
      t_priority();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule